// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous page-mode DRAM alive. Out of reset it counts a fixed power-up pause, then drives a fixed number of dummy row-strobe cycles on its own, without asking for the bus. Once those are done it raises init-done, and from then on an interval timer produces one refresh demand per interval. The interval is set so that all rows are covered inside the retention period: 4096 rows in 64 ms gives roughly one refresh every 15.6 us. Demands are raised on a request line toward the access controller and are carried out once a grant is returned.

Each refresh is one of two strobe patterns, picked per cycle by a mode input. The first lowers CAS# one clock before RAS# and needs no address. The second strobes RAS# alone while it drives the next row from an internal row counter that steps once per such cycle. Demands that the controller does not take in time are counted up to a limit, and the backlog is then issued back to back. Access grants for normal traffic pass through only after init-done and while no strobe cycle is running.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_n_o, cas_n_o and we_n_o are 1, and req_o, busy_o, init_done_o, row_oe_o and acc_gnt_o are 0.
- R2: No RAS# pulse occurs within the first PAUSE_CYC clock edges after reset release. The first init cycle starts at edge PAUSE_CYC+1.
- R3: After the pause, exactly INIT_CYC strobe cycles run without any grant. init_done_o rises on the edge after the last one finishes and stays 1 until reset.
- R4: acc_gnt_o equals acc_req_i when init_done_o is 1 and busy_o is 0. In all other cases it is 0.
- R5: After init, one refresh demand is added every INTERVAL_CYC edges, counting from the edge where init_done_o rose. req_o is 1 while demands are pending and stays 1 until a grant is accepted.
- R6: Pending demands saturate at BACKLOG_MAX. With gnt_i held at 1, a backlog is drained back to back, each new cycle starting on the edge after the previous one returns to idle.
- R7: When ras_only_i = 0 is sampled at the start of a cycle, cas_n_o goes to 0 for one clock before ras_n_o goes to 0. It returns to 1 together with ras_n_o. we_n_o stays 1 and row_oe_o stays 0.
- R8: When ras_only_i = 1 is sampled at the start of a cycle, cas_n_o stays 1 and row_oe_o is 1 exactly while ras_n_o is 0. row_o advances by one (modulo 2^ROW_W) on the edge where ras_n_o returns to 1.
- R9: Every RAS# low pulse lasts exactly T_RAS clocks and is followed by at least T_RP clocks of RAS# high.
- R10: busy_o is 1 from the start of a cycle until it returns to idle. A grant, or a change of ras_only_i, that arrives while busy has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh style: 0 = CAS#-before-RAS#, 1 = RAS#-only with row address |
| gnt_i | input | 1 | Bus grant from the access controller |
| acc_req_i | input | 1 | Normal access request from the controller |
| req_o | output | 1 | Refresh demand pending |
| busy_o | output | 1 | Strobe cycle in progress |
| init_done_o | output | 1 | Power-up pause and init cycles complete |
| acc_gnt_o | output | 1 | Normal access allowed this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |
| row_oe_o | output | 1 | Row address valid on row_o |
| row_o | output | ROW_W | Refresh row address |

## Verification
The properties assume that gnt_i and ras_only_i change only between clock edges and may take any value in any cycle. The block has to tolerate a grant while it is busy, a grant with nothing pending, and a mode change in the middle of a cycle. The bench drives these inputs at the falling edge with pseudo-random patterns, including long stretches without a grant and bursts of mode toggling. The bench's row counter is shortened so that wrap-around is reached within the run.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_LEAD, ENG_STROBE, ENG_PRECH} eng_state_e;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned PERIOD_CYC = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam int unsigned CW = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0] TOP = CW'(MAX_PEND);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)                 cnt_q <= cnt_q - 1'b1;
  end

  assign pend_o = (cnt_q != '0);
endmodule

// File: rtl/rfsh_strobe_gen.sv
module rfsh_strobe_gen
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned T_RAS = 8,
  parameter int unsigned T_RP  = 6,
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ras_only_i,
  output logic             idle_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             row_oe_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned TMAX = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);

  eng_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic             mode_q;  // 1: row-address style latched at start
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      row_q  <= '0;
    end else begin
      unique case (st_q)
        ENG_IDLE: if (start_i) begin
          mode_q <= ras_only_i;
          cnt_q  <= '0;
          st_q   <= ras_only_i ? ENG_STROBE : ENG_LEAD;
        end
        ENG_LEAD: begin
          cnt_q <= '0;
          st_q  <= ENG_STROBE;
        end
        ENG_STROBE: begin
          if (cnt_q == RAS_LAST) begin
            cnt_q <= '0;
            st_q  <= ENG_PRECH;
            if (mode_q) row_q <= row_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_PRECH: begin
          if (cnt_q == RP_LAST) st_q <= ENG_IDLE;
          else                  cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign idle_o   = (st_q == ENG_IDLE);
  assign ras_n_o  = (st_q != ENG_STROBE);
  assign cas_n_o  = !(!mode_q && (st_q == ENG_LEAD || st_q == ENG_STROBE));
  assign we_n_o   = 1'b1;
  assign row_oe_o = (st_q == ENG_STROBE) && mode_q;
  assign row_o    = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 12500, // 100 us at 8 ns
  parameter int unsigned INTERVAL_CYC = 1950,  // 15.6 us at 8 ns
  parameter int unsigned INIT_CYC     = 8,
  parameter int unsigned BACKLOG_MAX  = 8,
  parameter int unsigned T_RAS        = 8,
  parameter int unsigned T_RP         = 6,
  parameter int unsigned ROW_W        = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             gnt_i,
  input  logic             acc_req_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             init_done_o,
  output logic             acc_gnt_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             row_oe_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned IW = $clog2(INIT_CYC + 1);

  phase_e        phase_q;
  logic [IW-1:0] init_left_q;
  logic          pause_tick, ivl_tick, pend, eng_idle;
  logic          init_start, run_start;

  rfsh_interval_timer #(.PERIOD_CYC(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .en_i(phase_q == PH_PAUSE), .tick_o(pause_tick)
  );

  rfsh_interval_timer #(.PERIOD_CYC(INTERVAL_CYC)) u_ivl (
    .clk_i, .rst_ni, .en_i(phase_q == PH_RUN), .tick_o(ivl_tick)
  );

  rfsh_backlog #(.MAX_PEND(BACKLOG_MAX)) u_backlog (
    .clk_i, .rst_ni, .inc_i(ivl_tick), .dec_i(run_start), .pend_o(pend)
  );

  rfsh_strobe_gen #(.T_RAS(T_RAS), .T_RP(T_RP), .ROW_W(ROW_W)) u_strobe (
    .clk_i, .rst_ni,
    .start_i   (init_start | run_start),
    .ras_only_i,
    .idle_o    (eng_idle),
    .ras_n_o, .cas_n_o, .we_n_o, .row_oe_o, .row_o
  );

  assign init_start = (phase_q == PH_INIT) && eng_idle && (init_left_q != '0);
  assign run_start  = (phase_q == PH_RUN) && pend && gnt_i && eng_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PAUSE;
      init_left_q <= IW'(INIT_CYC);
    end else begin
      if (init_start) init_left_q <= init_left_q - 1'b1;
      unique case (phase_q)
        PH_PAUSE: if (pause_tick) phase_q <= PH_INIT;
        PH_INIT:  if (init_left_q == '0 && eng_idle) phase_q <= PH_RUN;
        default:  phase_q <= PH_RUN;
      endcase
    end
  end

  assign req_o       = pend;
  assign busy_o      = !eng_idle;
  assign init_done_o = (phase_q == PH_RUN);
  assign acc_gnt_o   = acc_req_i && init_done_o && eng_idle;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int unsigned T_RAS = 8,
  parameter int unsigned ROW_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gnt_i,
  input logic             req_o,
  input logic             busy_o,
  input logic             init_done_o,
  input logic             acc_gnt_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic             row_oe_o,
  input logic [ROW_W-1:0] row_o
);
  logic [15:0] lo_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_len_q <= '0;
    else if (!ras_n_o) lo_len_q <= lo_len_q + 1'b1;
    else               lo_len_q <= '0;
  end

  AST_ACC_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_gnt_o |-> (init_done_o && !busy_o)); // R4
  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R3
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o); // R5
  AST_CAS_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o && ras_n_o)); // R7
  AST_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> we_n_o); // R7
  AST_ROW_ONLY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_oe_o |-> (!ras_n_o && cas_n_o)); // R8
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && $past(row_oe_o)) |-> (row_o == ROW_W'($past(row_o) + 1'b1))); // R8
  AST_RAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_len_q == 16'(T_RAS))); // R9
  AST_RAS_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> busy_o); // R10
endmodule

bind dram_refresh_seq dram_refresh_chk #(.T_RAS(T_RAS), .ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gnt_i(gnt_i), .req_o(req_o), .busy_o(busy_o),
  .init_done_o(init_done_o), .acc_gnt_o(acc_gnt_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .row_oe_o(row_oe_o), .row_o(row_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
  localparam int PAUSE = 40, IVL = 60, NINIT = 8, QMAX = 3, TRAS = 8, TRP = 6, RW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_only = 1'b0, gnt = 1'b0, acc_req = 1'b0;
  logic req, busy, idone, agnt, ras_n, cas_n, we_n, row_oe;
  logic [RW-1:0] row;
  int n_run = 0, n_fail = 0, cyc = 0, falls = 0, init_falls = 0, first_fall = -1;
  logic ras_prev = 1'b1;

  always #4 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .INIT_CYC(NINIT),
    .BACKLOG_MAX(QMAX), .T_RAS(TRAS), .T_RP(TRP), .ROW_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_only_i(ras_only), .gnt_i(gnt), .acc_req_i(acc_req),
    .req_o(req), .busy_o(busy), .init_done_o(idone), .acc_gnt_o(agnt),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .row_oe_o(row_oe), .row_o(row));

  // behavioural reference model
  int m_ph, m_pc, m_il, m_tc, m_pend, m_st, m_sc, m_mode, m_row;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_il = NINIT; m_tc = 0; m_pend = 0;
      m_st = 0; m_sc = 0; m_mode = 0; m_row = 0;
    end else begin
      bit idl, istart, rstart, tick, ptick;
      idl    = (m_st == 0);
      istart = (m_ph == 1) && idl && (m_il != 0);
      rstart = (m_ph == 2) && (m_pend != 0) && gnt && idl;
      tick   = (m_ph == 2) && (m_tc == IVL - 1);
      ptick  = (m_ph == 0) && (m_pc == PAUSE - 1);
      m_pc = (m_ph == 0 && !ptick) ? m_pc + 1 : 0;
      m_tc = (m_ph == 2 && !tick) ? m_tc + 1 : 0;
      if (tick && !rstart) m_pend = (m_pend < QMAX) ? m_pend + 1 : QMAX;
      else if (rstart && !tick) m_pend--;
      if (istart) m_il--;
      if (m_ph == 0 && ptick) m_ph = 1;
      else if (m_ph == 1 && m_il == 0 && idl && !istart) m_ph = 2;
      case (m_st)
        0: if (istart || rstart) begin m_mode = ras_only; m_sc = 0; m_st = ras_only ? 2 : 1; end
        1: begin m_st = 2; m_sc = 0; end
        2: if (m_sc == TRAS - 1) begin
             m_st = 3; m_sc = 0;
             if (m_mode == 1) m_row = (m_row + 1) % (1 << RW);
           end else m_sc++;
        default: if (m_sc == TRP - 1) m_st = 0; else m_sc++;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9 ras_n", ras_n, (m_st != 2));
    chk("R7 cas_n", cas_n, !(m_mode == 0 && (m_st == 1 || m_st == 2)));
    chk("R7 we_n", we_n, 1);
    chk("R8 row_oe", row_oe, (m_st == 2 && m_mode == 1));
    chk("R8 row", row, m_row);
    chk("R5 req", req, (m_pend != 0));
    chk("R10 busy", busy, (m_st != 0));
    chk("R3 init_done", idone, (m_ph == 2));
    chk("R4 acc_gnt", agnt, (acc_req && m_ph == 2 && m_st == 0));
  endtask

  // one falling edge: compare, track RAS# falls
  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      compare();
      if (ras_prev && !ras_n) begin
        falls++;
        if (!idone) init_falls++;
        if (first_fall < 0) first_fall = cyc;
      end
      ras_prev = ras_n;
    end
  endtask

  task automatic rnd(int n, int gpct, int mode_sel);
    repeat (n) begin
      step(1);
      gnt     = (($urandom % 100) < gpct);
      acc_req = $urandom % 2;
      if (mode_sel == 2) ras_only = $urandom % 2;
      else               ras_only = mode_sel[0];
    end
  endtask

  initial begin
    #20;
    chk("R1 ras_n reset", ras_n, 1); chk("R1 cas_n reset", cas_n, 1);
    chk("R1 req reset", req, 0);     chk("R1 busy reset", busy, 0);
    chk("R1 init reset", idone, 0);  chk("R1 row_oe reset", row_oe, 0);
    acc_req = 1'b1;
    #1 chk("R1 acc_gnt reset", agnt, 0);
    @(negedge clk); rst_n = 1'b1;
    // init phase, grants withheld, mode toggling
    while (!idone && cyc < 2000) rnd(1, 0, 2);
    chk("R2 first RAS after pause", (first_fall > PAUSE), 1);
    chk("R3 init cycle count", init_falls, NINIT);
    // steady CBR refresh with random grants
    rnd(800, 40, 0);
    // row-address style, wrap of the short row counter
    begin
      int f0;
      logic [RW-1:0] r0;
      rnd(1, 100, 1);
      while (busy) rnd(1, 0, 1);
      r0 = row; f0 = falls;
      rnd(1500, 100, 1);
      while (busy) rnd(1, 0, 1);
      chk("R8 row after wrap", row, (r0 + (falls - f0)) % (1 << RW));
      chk("R8 wrap reached", (falls - f0) >= (1 << RW), 1);
    end
    // backlog: withhold grant for several intervals, then drain
    gnt = 1'b0; ras_only = 1'b1;
    step(5 * IVL);
    chk("R5 req held without grant", req, 1);
    chk("R6 idle while waiting", busy, 0);
    begin
      int f0;
      f0 = falls;
      gnt = 1'b1;
      step(5 * (TRAS + TRP));
      chk("R6 backlog saturation", ((falls - f0) >= QMAX) && ((falls - f0) <= QMAX + 1), 1);
    end
    // mixed modes and grants mid-cycle
    rnd(1500, 50, 2);
    rnd(600, 5, 2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule